// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches firmware liveness from a slow crystal clock. A fixed binary prescaler divides the clock by 2^PRE_W, which is 8192 by default. Its carry drives a second counter. A two-bit tap select picks which power-of-two length of that counter counts as a time-out. When a time-out occurs, the block sets a sticky time-out flag. If interrupts are enabled, the flag also raises an interrupt request.

A time-out also opens a grace window of RST_DELAY clocks, 512 by default. If the firmware issues a restart strobe inside the window, the reset is cancelled. If no restart arrives and the reset enable is on, the block emits a one-clock reset pulse when the window closes. It also sets a reset-cause flag that outlives that pulse. Software clears the two flags with clear strobes. The restart command is a strobe that needs no clearing.

The control state machine has three states:
- RUN: counting.
- ARMED: the grace window is running.
- FIRE: the reset pulse cycle.

It has these transitions:
- RUN to ARMED on an accepted time-out.
- ARMED to FIRE when the window ends with the reset enabled.
- ARMED to RUN when the window ends with the reset disabled.
- FIRE to RUN after one clock.
- Any state to RUN on a restart.

Top module: `wdt_two_stage`

## Requirements
- R1: After the asynchronous reset, `wdt_rst`, `tout_flag`, `cause_flag` and `irq` are all 0.
- R2: The time-out flag sets exactly 2^PRE_W * 2^(TAP_BASE + TAP_STEP*sel) clocks after the counters were cleared. With the default parameters, `sel` = 00, 01, 10 and 11 select 2^6, 2^9, 2^12 and 2^15 prescaled ticks respectively.
- R3: `irq` is 1 exactly while `tout_flag` is 1 and `irq_en` is 1.
- R4: With `rst_en` at 1 and no restart, `wdt_rst` rises exactly RST_DELAY clocks after the clock edge that set the time-out flag.
- R5: `wdt_rst` is never high for two consecutive clocks.
- R6: A `restart` strobe clears all counters and returns the machine to RUN. A strobe inside the grace window prevents the pending reset, and the next time-out comes a full period after the strobe.
- R7: If `rst_en` is 0 when the window ends, no reset pulse is produced, and counting goes on from its current value.
- R8: `cause_flag` sets in the same cycle as the reset pulse. It stays set through later pulses and is cleared only by `clr_cause` or the asynchronous reset. If a set and a clear coincide, the set wins.
- R9: `tout_flag` stays set until `clr_flag`. If a set and a clear coincide, the set wins. A time-out during the grace window does not restart the window.
- R10: After a reset pulse, all counters are zero. The next time-out comes a full period after the pulse, so with a fixed tap the pulse period is period + RST_DELAY + 1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| irq_en | input | 1 | Interrupt enable |
| rst_en | input | 1 | Reset enable |
| tap_sel | input | 2 | Time-out tap select |
| restart | input | 1 | Restart strobe (self-clearing command) |
| clr_flag | input | 1 | Clear strobe for the time-out flag |
| clr_cause | input | 1 | Clear strobe for the reset-cause flag |
| irq | output | 1 | Interrupt request |
| wdt_rst | output | 1 | One-clock watchdog reset pulse |
| tout_flag | output | 1 | Sticky time-out flag |
| cause_flag | output | 1 | Sticky reset-cause flag |

## Verification
On every cycle, the assertions check these properties:
- The reset pulse is one clock wide.
- A pulse never follows a restart.
- A pulse only appears with the reset enabled and is always accompanied by the cause flag.
- Both flags hold unless their clear strobe is present.

The exact time-out length for each tap and the exact grace-window length need the bench's cycle-accurate reference model. The same applies to the cancellation by a restart, the disabled-reset path and the restart of counting after a pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRE_W = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    assign tick = &cnt_q;
endmodule

// File: rtl/wdt_divider.sv
module wdt_divider #(
    parameter int TAP_BASE = 6,
    parameter int TAP_STEP = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] tap_sel,
    output logic       evt
);
    localparam int DIV_W = TAP_BASE + 3 * TAP_STEP;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] mask_tab [4];
    logic [DIV_W-1:0] mask;

    for (genvar g = 0; g < 4; g++) begin : g_tap
        localparam int EXP = TAP_BASE + TAP_STEP * g;
        assign mask_tab[g] = DIV_W'((64'd1 << EXP) - 64'd1);
    end

    assign mask = mask_tab[tap_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    assign evt = tick && ((cnt_q & mask) == mask);
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int RST_DELAY = 512
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      evt,
    input  logic      rst_en,
    output wd_state_e state,
    output logic      tout_ok,
    output logic      go_fire,
    output logic      cnt_clr,
    output logic      pulse
);
    localparam int DW = $clog2(RST_DELAY + 1);

    wd_state_e      nxt;
    logic [DW-1:0]  dly_q;
    logic [DW-1:0]  dly_d;
    logic           win_end;

    assign win_end = (dly_q == DW'(RST_DELAY - 1));

    always_comb begin
        nxt   = state;
        dly_d = '0;
        if (restart) begin
            nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (evt) nxt = ST_ARMED;
                end
                ST_ARMED: begin
                    if (win_end) nxt = rst_en ? ST_FIRE : ST_RUN;
                    else         dly_d = dly_q + 1'b1;
                end
                ST_FIRE: nxt = ST_RUN;
                default: nxt = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            dly_q <= '0;
        end else begin
            state <= nxt;
            dly_q <= dly_d;
        end
    end

    always_comb begin
        pulse   = (state == ST_FIRE);
        go_fire = (state == ST_ARMED) && (nxt == ST_FIRE);
        tout_ok = evt && !restart && (state != ST_FIRE);
        cnt_clr = restart || pulse || go_fire;
    end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int PRE_W     = 13,
    parameter int TAP_BASE  = 6,
    parameter int TAP_STEP  = 3,
    parameter int RST_DELAY = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_en,
    input  logic       rst_en,
    input  logic [1:0] tap_sel,
    input  logic       restart,
    input  logic       clr_flag,
    input  logic       clr_cause,
    output logic       irq,
    output logic       wdt_rst,
    output logic       tout_flag,
    output logic       cause_flag
);
    logic      tick;
    logic      evt;
    logic      tout_ok;
    logic      go_fire;
    logic      cnt_clr;
    wd_state_e state;

    wdt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick)
    );

    wdt_divider #(.TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick),
        .tap_sel(tap_sel), .evt(evt)
    );

    wdt_fsm #(.RST_DELAY(RST_DELAY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .restart(restart), .evt(evt),
        .rst_en(rst_en), .state(state), .tout_ok(tout_ok),
        .go_fire(go_fire), .cnt_clr(cnt_clr), .pulse(wdt_rst)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tout_flag  <= 1'b0;
            cause_flag <= 1'b0;
        end else begin
            if (tout_ok)       tout_flag <= 1'b1;
            else if (clr_flag) tout_flag <= 1'b0;
            if (go_fire)        cause_flag <= 1'b1;
            else if (clr_cause) cause_flag <= 1'b0;
        end
    end

    assign irq = tout_flag & irq_en;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk (
    input logic clk,
    input logic rst_n,
    input logic rst_en,
    input logic restart,
    input logic clr_flag,
    input logic clr_cause,
    input logic wdt_rst,
    input logic tout_flag,
    input logic cause_flag
);
    a_r5_one_clock_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    a_r6_restart_blocks_reset: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !wdt_rst);

    a_r7_reset_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> $past(rst_en));

    a_r8_cause_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> cause_flag);

    a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_flag && !clr_cause) |=> cause_flag);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_flag && !clr_flag) |=> tout_flag);
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rst_en(rst_en), .restart(restart),
    .clr_flag(clr_flag), .clr_cause(clr_cause), .wdt_rst(wdt_rst),
    .tout_flag(tout_flag), .cause_flag(cause_flag)
);

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;
    localparam int PRE_W = 2, TB = 1, TS = 1, DLY = 20;
    localparam int P = 1 << PRE_W;

    logic clk = 0, rst_n = 0;
    logic irq_en = 0, rst_en = 0, restart = 0, clr_flag = 0, clr_cause = 0;
    logic [1:0] tap_sel = 0;
    logic irq, wdt_rst, tout_flag, cause_flag;

    int errors = 0, checks = 0, pulses = 0, run = 0, maxrun = 0, cyc = 0;
    // reference model
    int m_st = 0, m_dly = 0, m_el = 0;
    bit m_flag = 0, m_cause = 0;

    wdt_two_stage #(.PRE_W(PRE_W), .TAP_BASE(TB), .TAP_STEP(TS), .RST_DELAY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .rst_en(rst_en),
        .tap_sel(tap_sel), .restart(restart), .clr_flag(clr_flag),
        .clr_cause(clr_cause), .irq(irq), .wdt_rst(wdt_rst),
        .tout_flag(tout_flag), .cause_flag(cause_flag)
    );

    always #2 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_dly = 0; m_el = 0; m_flag = 0; m_cause = 0;
        end else begin
            int per, nst, ndly;
            bit to, fire_in;
            per = P << (TB + TS * int'(tap_sel));
            to = !restart && m_st != 2 && ((m_el + 1) % per == 0);
            nst = m_st; ndly = 0;
            if (restart) nst = 0;
            else if (m_st == 0) begin if (to) nst = 1; end
            else if (m_st == 1) begin
                if (m_dly == DLY - 1) nst = rst_en ? 2 : 0;
                else ndly = m_dly + 1;
            end else nst = 0;
            fire_in = (m_st == 1) && (nst == 2);
            if (restart || m_st == 2 || fire_in) m_el = 0; else m_el++;
            if (to) m_flag = 1; else if (clr_flag) m_flag = 0;
            if (fire_in) m_cause = 1; else if (clr_cause) m_cause = 0;
            m_st = nst; m_dly = ndly;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R4 wdt_rst", wdt_rst, m_st == 2);
            chk("R2 tout_flag", tout_flag, m_flag);
            chk("R3 irq", irq, m_flag && irq_en);
            chk("R8 cause_flag", cause_flag, m_cause);
            if (wdt_rst) begin pulses++; run++; if (run > maxrun) maxrun = run; end
            else run = 0;
        end
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic strobe(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        int p0;
        idle(2);
        chk("R1 wdt_rst", wdt_rst, 0);
        chk("R1 tout_flag", tout_flag, 0);
        chk("R1 cause_flag", cause_flag, 0);
        chk("R1 irq", irq, 0);
        @(negedge clk); rst_n = 1;
        // R4/R2: shortest tap, reset enabled
        irq_en = 1; rst_en = 1; tap_sel = 0;
        strobe(restart);
        idle(8 + DLY + 6);
        expect_int("R4 pulse count", pulses, 1);
        chk("R8 cause after pulse", cause_flag, 1);
        // R9/R8: clearing flags
        strobe(clr_flag); strobe(clr_cause);
        idle(1);
        // R6: restart inside grace window
        tap_sel = 1;
        strobe(restart);
        idle(18);
        chk("R6 flag set before cancel", tout_flag, 1);
        p0 = pulses;
        strobe(restart);
        idle(10);
        expect_int("R6 no pulse after restart", pulses, p0);
        strobe(clr_flag);
        // R7: reset disabled, slowest tap, interrupts off
        rst_en = 0; irq_en = 0; tap_sel = 3;
        strobe(restart);
        p0 = pulses;
        idle(64 + DLY + 20);
        expect_int("R7 no pulse when disabled", pulses, p0);
        chk("R7 flag set", tout_flag, 1);
        chk("R3 irq masked", irq, 0);
        irq_en = 1; idle(2);
        chk("R3 irq follows flag", irq, 1);
        // R10: repeated pulses with cause kept
        rst_en = 1; tap_sel = 0;
        strobe(restart);
        p0 = pulses;
        idle(200);
        expect_int("R10 pulse count in 200 clocks", (pulses - p0 >= 6) ? 1 : 0, 1);
        chk("R8 cause survives pulses", cause_flag, 1);
        tap_sel = 2; idle(150);
        expect_int("R5 max pulse width", maxrun, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule